// File: doc/BRIEF.md
# ADC Calibration Mode Sequencer

This block is the control sequencer that sits between the configuration registers of a sigma-delta converter and an abstract conversion engine. Software writes a 3-bit operating mode, a channel number and a gain code together, in one strobe. From then on the sequencer tells the engine what each engine cycle is for. A cycle can be a plain measurement, a zero-scale point on the applied input, a zero-scale point on shorted inputs, or a full-scale point on the internal reference. The engine ends each cycle with a one-cycle done strobe.

The sequencer discards the first engine cycles after any restart so that the filter can settle. It then commits the result of the cycle as one of three things: a data word, an offset coefficient or a full-scale coefficient. It keeps the data-ready flag (`drdy_o`) and, after a one-shot calibration, writes the mode field back to normal.

In background mode, a calibration on shorted inputs is woven into the measurement stream. Only the offset coefficient is refreshed, and one word comes out for every six engine cycles. A filter-sync input holds the engine and the sequencing in reset while it is high.

Top module: `cal_seq_top`

## Requirements
- R1: After reset, the outputs are as follows: `drdy_o` is 1, `mode_o` is 000 and `eng_kind_o` is 00. All commit strobes are low.
- R2: Three done strobes are accepted after any restart (reset, config write, filter-sync, step change). On the third, the step commits. In normal mode, the third accepted done and every accepted done after it pulse `data_we_o` in the same cycle. `eng_kind_o` uses four codes: 00 is measure, 01 is zero on the applied input, 10 is zero on shorted inputs and 11 is full-scale on the internal reference.
- R3: `drdy_o` goes to 0 in the cycle after a `data_we_o` pulse. It goes to 1 after a config write or a `data_rd_i` pulse. When a word commit and a read fall in the same cycle, the flag ends at 0.
- R4: Mode 110 presents kind 10 and pulses `ofs_we_o` on its third done. From the next cycle, `mode_o` reads 000. The block then settles normal measurement, and the first word comes on the third done after that.
- R5: Mode 111 behaves the same way as R4, but with kind 11 and `fs_we_o`.
- R6: Mode 100 first runs kind 01 and pulses `ofs_we_o` on its third done. It then runs kind 11 and pulses `fs_we_o` on its third done. After that it clears the mode to 000 and continues as in R4.
- R7: Mode 101 repeats a fixed pattern: three dones of kind 10 ending in `ofs_we_o`, then three dones of kind 00 ending in `data_we_o`. `mode_o` stays 101 and `fs_we_o` never pulses. This gives exactly one word per six dones.
- R8: Codes 001, 010 and 011 are stored as 000 and behave as normal mode.
- R9: A config write during any step restarts the sequence in the new mode. A done strobe in the same cycle as the write is discarded.
- R10: `eng_rst_o` follows `fsync_i`. While it is high, dones are ignored and nothing commits. The first commit is on the third done after it falls. Filter-sync on its own never changes `drdy_o`.
- R11: `gain_o` is 2 to the power of the gain code latched at the last config write, so code 0 gives 1 and code 7 gives 128. `chan_o` is the channel latched at the same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Strobe that writes the mode, channel and gain |
| mode_i | input | 3 | Operating-mode code |
| chan_i | input | CHAN_W | Channel select |
| gain_code_i | input | GAIN_W | Gain exponent |
| fsync_i | input | 1 | Filter sync; holds the sequencing in reset |
| eng_done_i | input | 1 | The engine has completed a cycle |
| data_rd_i | input | 1 | The data word has been read |
| mode_o | output | 3 | Current mode field |
| chan_o | output | CHAN_W | Latched channel |
| gain_o | output | 2**GAIN_W | Decoded gain |
| eng_rst_o | output | 1 | Engine held in reset |
| eng_kind_o | output | 2 | Purpose of the current engine cycle |
| data_we_o | output | 1 | Commit a data word |
| ofs_we_o | output | 1 | Commit the offset coefficient |
| fs_we_o | output | 1 | Commit the full-scale coefficient |
| drdy_o | output | 1 | Data ready, active low |

## Verification
A word commit can arrive in the same cycle as a host read of the previous word. The bench provokes this by holding `drdy_o` low and then raising `data_rd_i` in the very cycle a settled done arrives. The flag must stay low, because the new word has not been read.

A second collision is a config write that lands together with a done strobe in the middle of a calibration. The bench checks that no coefficient is committed, the new mode takes over, and the settling count restarts from zero.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
  localparam logic [2:0] MD_NORM    = 3'b000;
  localparam logic [2:0] MD_SYS_OFS = 3'b100;
  localparam logic [2:0] MD_BG      = 3'b101;
  localparam logic [2:0] MD_ZERO    = 3'b110;
  localparam logic [2:0] MD_FULL    = 3'b111;

  typedef enum logic [1:0] {
    K_MEAS = 2'b00,
    K_ZSYS = 2'b01,
    K_ZINT = 2'b10,
    K_FINT = 2'b11
  } kind_e;

  typedef enum logic [2:0] {
    S_NORM, S_ZSYS, S_ZINT, S_FINT, S_BGN
  } state_e;

  function automatic logic [2:0] norm_mode(input logic [2:0] m);
    return m[2] ? m : MD_NORM;
  endfunction

  function automatic state_e entry_state(input logic [2:0] m);
    case (m)
      MD_SYS_OFS: return S_ZSYS;
      MD_BG,
      MD_ZERO:    return S_ZINT;
      MD_FULL:    return S_FINT;
      default:    return S_NORM;
    endcase
  endfunction
endpackage

// File: rtl/cal_gain_dec.sv
module cal_gain_dec #(
  parameter int CODE_W = 3
) (
  input  logic [CODE_W-1:0]      code_i,
  output logic [(1<<CODE_W)-1:0] gain_o
);
  localparam int N = 1 << CODE_W;
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign gain_o[i] = (code_i == CODE_W'(i));
  end
endmodule

// File: rtl/cal_step_ctr.sv
module cal_step_ctr #(
  parameter int SETTLE_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int PH_W = $clog2(SETTLE_CYC + 1);
  localparam logic [PH_W-1:0] LAST = PH_W'(SETTLE_CYC - 1);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   ph_q <= '0;
    else if (clr_i)                ph_q <= '0;
    else if (inc_i && ph_q != LAST) ph_q <= ph_q + 1'b1;
  end

  assign last_o = (ph_q == LAST);

  // R2
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= LAST);
endmodule

// File: rtl/cal_drdy_ctl.sv
module cal_drdy_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic word_i,
  input  logic set_i,
  output logic drdy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     drdy_o <= 1'b1;
    else if (word_i) drdy_o <= 1'b0;  // fresh word beats a read
    else if (set_i)  drdy_o <= 1'b1;
  end
endmodule

// File: rtl/cal_seq_top.sv
module cal_seq_top
  import cal_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 3,
  parameter int CHAN_W     = 3,
  parameter int GAIN_W     = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cfg_wr_i,
  input  logic [2:0]                mode_i,
  input  logic [CHAN_W-1:0]         chan_i,
  input  logic [GAIN_W-1:0]         gain_code_i,
  input  logic                      fsync_i,
  input  logic                      eng_done_i,
  input  logic                      data_rd_i,
  output logic [2:0]                mode_o,
  output logic [CHAN_W-1:0]         chan_o,
  output logic [(1<<GAIN_W)-1:0]    gain_o,
  output logic                      eng_rst_o,
  output logic [1:0]                eng_kind_o,
  output logic                      data_we_o,
  output logic                      ofs_we_o,
  output logic                      fs_we_o,
  output logic                      drdy_o
);
  state_e            st_q, st_d;
  logic [2:0]        mode_q, mode_d;
  logic [CHAN_W-1:0] chan_q;
  logic [GAIN_W-1:0] gain_q;
  kind_e             kind;
  logic              acc_done, last, commit, step_adv;

  assign acc_done = eng_done_i & ~fsync_i & ~cfg_wr_i;
  assign commit   = acc_done & last;
  assign step_adv = commit & (st_q != S_NORM);

  cal_step_ctr #(.SETTLE_CYC(SETTLE_CYC)) u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cfg_wr_i | fsync_i | step_adv),
    .inc_i  (acc_done),
    .last_o (last)
  );

  always_comb begin
    case (st_q)
      S_ZSYS:  kind = K_ZSYS;
      S_ZINT:  kind = K_ZINT;
      S_FINT:  kind = K_FINT;
      default: kind = K_MEAS;
    endcase
  end

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    if (cfg_wr_i) begin
      st_d   = entry_state(mode_i);
      mode_d = norm_mode(mode_i);
    end else if (commit) begin
      case (st_q)
        S_ZSYS: st_d = S_FINT;
        S_ZINT: begin
          if (mode_q == MD_BG) st_d = S_BGN;
          else begin
            st_d   = S_NORM;
            mode_d = MD_NORM;
          end
        end
        S_FINT: begin
          st_d   = S_NORM;
          mode_d = MD_NORM;
        end
        S_BGN:   st_d = S_ZINT;
        default: st_d = S_NORM;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_NORM;
      mode_q <= MD_NORM;
      chan_q <= '0;
      gain_q <= '0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      if (cfg_wr_i) begin
        chan_q <= chan_i;
        gain_q <= gain_code_i;
      end
    end
  end

  cal_gain_dec #(.CODE_W(GAIN_W)) u_gain (
    .code_i (gain_q),
    .gain_o (gain_o)
  );

  assign data_we_o  = commit & ((st_q == S_NORM) | (st_q == S_BGN));
  assign ofs_we_o   = commit & ((st_q == S_ZSYS) | (st_q == S_ZINT));
  assign fs_we_o    = commit & (st_q == S_FINT);
  assign eng_rst_o  = fsync_i;
  assign eng_kind_o = kind;
  assign mode_o     = mode_q;
  assign chan_o     = chan_q;

  cal_drdy_ctl u_drdy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .word_i (data_we_o),
    .set_i  (cfg_wr_i | data_rd_i),
    .drdy_o (drdy_o)
  );

  // R3
  word_drdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_o |=> !drdy_o);
  // R9
  wr_drdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> drdy_o);
  // R10
  fsync_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_i |-> !(data_we_o | ofs_we_o | fs_we_o));
  // R10
  fsync_drdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsync_i && !cfg_wr_i && !data_rd_i) |=> $stable(drdy_o));
  // R7
  bg_no_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MD_BG) |-> !fs_we_o);
  // R5
  full_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_we_o |=> (mode_o == MD_NORM));
  // R2
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({data_we_o, ofs_we_o, fs_we_o}));
endmodule

// File: tb/cal_seq_top_tb_top.sv
module cal_seq_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0, fsync = 1'b0, done = 1'b0, rd = 1'b0;
  logic [2:0] md = '0, ch = '0, gc = '0;
  logic [2:0] mode_o, chan_o;
  logic [7:0] gain_o;
  logic       eng_rst_o, data_we_o, ofs_we_o, fs_we_o, drdy_o;
  logic [1:0] eng_kind_o;

  int n_chk = 0, n_fail = 0;
  int m_mode = 0, m_cnt = 0, m_chan = 0, m_gain = 0;
  int q[$];
  bit m_bg = 0, m_drdy = 1, auto_rd = 1, prev_drdy = 1;
  int words = 0, falls = 0;

  always #2 clk = ~clk;

  cal_seq_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .mode_i(md), .chan_i(ch),
    .gain_code_i(gc), .fsync_i(fsync), .eng_done_i(done), .data_rd_i(rd),
    .mode_o(mode_o), .chan_o(chan_o), .gain_o(gain_o), .eng_rst_o(eng_rst_o),
    .eng_kind_o(eng_kind_o), .data_we_o(data_we_o), .ofs_we_o(ofs_we_o),
    .fs_we_o(fs_we_o), .drdy_o(drdy_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit wr = 0, input logic [2:0] code = 0,
                     input bit fs = 0, input bit dn = 0, input bit r = 0);
    int k, e_word, e_ofs, e_fs;
    bit rr;
    rr = r | (auto_rd & !m_drdy);
    cfg_wr = wr; md = code; fsync = fs; done = dn; rd = rr;
    #1;
    k = (q.size() != 0) ? q[0] : 0;
    e_word = 0; e_ofs = 0; e_fs = 0;
    if (!wr && !fs && dn && m_cnt == 2) begin
      if (k == 0) e_word = 1;
      else if (k == 3) e_fs = 1;
      else e_ofs = 1;
    end
    chk("R2 data_we", data_we_o, e_word);
    chk("R7 ofs_we", ofs_we_o, e_ofs);
    chk("R5 fs_we", fs_we_o, e_fs);
    chk("R6 eng_kind", eng_kind_o, k);
    chk("R3 drdy", drdy_o, m_drdy);
    chk("R4 mode", mode_o, m_mode);
    chk("R10 eng_rst", eng_rst_o, fs);
    chk("R11 gain", gain_o, 1 << m_gain);
    chk("R11 chan", chan_o, m_chan);
    if (data_we_o) words++;
    if (prev_drdy && !drdy_o) falls++;
    prev_drdy = drdy_o;
    // reference update
    if (wr) begin
      m_mode = code[2] ? int'(code) : 0;
      q.delete(); m_bg = 0;
      case (m_mode)
        4: begin q.push_back(1); q.push_back(3); end
        5: begin q.push_back(2); q.push_back(0); m_bg = 1; end
        6: q.push_back(2);
        7: q.push_back(3);
        default: ;
      endcase
      m_cnt = 0; m_chan = ch; m_gain = gc;
    end else if (fs) m_cnt = 0;
    else if (dn) begin
      if (m_cnt < 2) m_cnt++;
      else if (q.size() != 0) begin
        void'(q.pop_front());
        m_cnt = 0;
        if (q.size() == 0) begin
          if (m_bg) begin q.push_back(2); q.push_back(0); end
          else if (k != 0) m_mode = 0;
        end
      end
    end
    if (e_word) m_drdy = 0;
    else if (wr || rr) m_drdy = 1;
    @(posedge clk); @(negedge clk);
    cfg_wr = 0; done = 0; rd = 0;
  endtask

  task automatic dones(input int n, input int gap = 2, input bit fs = 0);
    for (int i = 0; i < n; i++) begin
      cyc(0, 0, fs, 1, 0);
      for (int j = 1; j < gap; j++) cyc(0, 0, fs, 0, 0);
    end
  endtask

  initial begin
    #(4ns * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(); cyc();                       // R1 reset state
    dones(5, 3);                        // R2 normal settling then words
    auto_rd = 0;
    dones(1);
    cyc(0, 0, 0, 1, 1);                 // R3 commit and read collide
    cyc(0, 0, 0, 0, 1);
    auto_rd = 1;
    ch = 5; gc = 7; cyc(1, 3'b000);     // R11 gain 128
    dones(3);
    ch = 2; gc = 0; cyc(1, 3'b000);     // R11 gain 1
    cyc(1, 3'b110); dones(8);           // R4
    cyc(1, 3'b111); dones(8);           // R5
    cyc(1, 3'b100); dones(11);          // R6
    cyc(1, 3'b011); dones(4);           // R8 unused code
    cyc(1, 3'b010); dones(3);           // R8
    cyc(1, 3'b100); dones(2);
    cyc(1, 3'b110, 0, 1);               // R9 abort with a done in the write cycle
    dones(7);
    auto_rd = 0;
    cyc(1, 3'b000); dones(3);
    dones(3, 2, 1);                     // R10 drdy stays low under fsync
    dones(4);
    auto_rd = 1;
    cyc(1, 3'b111); dones(2);
    dones(2, 2, 1);                     // R10 fsync mid calibration
    dones(7);
    cyc(1, 3'b101);                     // R7 background
    words = 0; falls = 0;
    dones(60);
    chk("R7 words per 60 dones", words, 10);
    chk("R7 drdy falls per 60 dones", falls, 10);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule